// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block steps one vector-prefixed register-to-register operation across a vector length. A single start pulse brings in the length, three base register numbers (destination, source A, source B), a scalar/vector marker for each of those three operands, and a result-recording enable. The block then offers one element operation per cycle on a valid/ready issue port. Each offer carries the destination and both source register numbers resolved for that element. It also carries the condition field index that the element writes when recording is on.

The block also takes back the element result on the cycle that the element is accepted. It turns that result into a 4-bit condition code for the element. It signals completion with a one-cycle done pulse. If a resolved register number would leave the 32-entry register space, it stops the loop and raises a one-cycle error pulse instead of done.

Top module: `vec_elem_seq`

## Requirements
- R1: A start pulse is accepted only while `busy_o` is low. A start that arrives while busy has no effect on the current loop's register numbers, element count or completion.
- R2: With a vector destination and a non-zero length L, exactly L elements are issued. The `issue_crf_o` index of each issued element counts 0, 1, ... L-1 in order.
- R3: A length of zero issues no element. In that case `done_o` is high combinationally in the same cycle as the accepted start, and `busy_o` stays low.
- R4: For an operand marked vector (marker bit = 1), the register number of element i is its base plus i.
- R5: For an operand marked scalar (marker bit = 0), the register number is its base for every element.
- R6: A scalar destination ends the loop after element 0 for any non-zero length. No later element is issued.
- R7: Each issued element carries its element index on `issue_crf_o` as the condition field it writes. It also carries the latched recording enable on `issue_rec_o`.
- R8: `cc_valid_o` is high exactly on handshake cycles. In those cycles `cc_o` is 4'b1000 for a negative result, 4'b0100 for a positive result and 4'b0010 for a zero result, with the result read as signed 64-bit. Bit 0 copies `so_i`.
- R9: The element index advances only on a cycle where `issue_valid_o` and `issue_ready_i` are both high. While the issue port is stalled, all issue fields hold steady.
- R10: `done_o` is a one-cycle pulse in the cycle after the last element's handshake, with `busy_o` low in that cycle.
- R11: If any vector operand's register number for the next element would exceed 31, that element is not issued. The loop aborts, `err_o` pulses for one cycle after the abort and `done_o` does not pulse.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a loop (taken only while idle) |
| vlen_i | input | 7 | Vector length |
| dst_base_i | input | 5 | Destination base register |
| srca_base_i | input | 5 | Source A base register |
| srcb_base_i | input | 5 | Source B base register |
| dst_vec_i | input | 1 | Destination is vector (1) or scalar (0) |
| srca_vec_i | input | 1 | Source A is vector (1) or scalar (0) |
| srcb_vec_i | input | 1 | Source B is vector (1) or scalar (0) |
| rec_en_i | input | 1 | Result recording enable |
| issue_ready_i | input | 1 | Execution side accepts the offered element |
| result_i | input | 64 | Element result, taken on the handshake cycle |
| so_i | input | 1 | Summary overflow, copied to condition bit 0 |
| issue_valid_o | output | 1 | An element operation is offered |
| issue_dst_o | output | 5 | Resolved destination register |
| issue_srca_o | output | 5 | Resolved source A register |
| issue_srcb_o | output | 5 | Resolved source B register |
| issue_crf_o | output | 7 | Condition field index (element index) |
| issue_rec_o | output | 1 | Recording enable for this element |
| cc_valid_o | output | 1 | Condition code valid |
| cc_o | output | 4 | Element condition code |
| busy_o | output | 1 | Loop in progress |
| done_o | output | 1 | Loop completed pulse |
| err_o | output | 1 | Register range abort pulse |

## Verification
The element handshake does two things in one cycle. It takes back the result that becomes the condition code, and it advances the element index that resolves the next register numbers. The bench also runs the final handshake and the step into idle together. It provokes these by sweeping lengths 0 to 5 over all eight scalar/vector marker combinations, with the ready input either held high or toggling every cycle. It varies the result sign and `so_i` per element. In each accepted cycle it judges the code against that element's own result. It judges the register numbers of the next offer against base plus the incremented index, so a stall that leaks into the index is caught. The bench also drives loops whose vector operands run past register 31, and a start that arrives mid-loop.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
    localparam int VL_W   = 7;
    localparam int REG_W  = 5;
    localparam int DATA_W = 64;
    localparam int N_OPS  = 3;   // 0 = destination, 1 = source A, 2 = source B

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_st_e;

    typedef struct packed {
        seq_st_e                      st;
        logic [VL_W-1:0]              elem;
        logic [VL_W-1:0]              vl;
        logic [N_OPS-1:0][REG_W-1:0]  base;
        logic [N_OPS-1:0]             vec;
        logic                         rec;
        logic                         done;
        logic                         err;
    } seq_state_t;
endpackage

// File: rtl/vseq_regcalc.sv
module vseq_regcalc #(
    parameter int REG_W = 5,
    parameter int VL_W  = 7
) (
    input  logic [REG_W-1:0] base_i,
    input  logic             vec_i,
    input  logic [VL_W-1:0]  elem_i,
    output logic [REG_W-1:0] reg_o,
    output logic             ovf_o
);
    localparam int SUM_W = ((VL_W > REG_W) ? VL_W : REG_W) + 1;
    localparam logic [SUM_W-1:0] REG_MAX = SUM_W'((1 << REG_W) - 1);

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum   = SUM_W'(base_i) + (vec_i ? SUM_W'(elem_i) : '0);
        reg_o = sum[REG_W-1:0];
        ovf_o = (sum > REG_MAX);
    end
endmodule

// File: rtl/vseq_ccgen.sv
module vseq_ccgen #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] result_i,
    input  logic              so_i,
    output logic [3:0]        cc_o
);
    logic neg, zero;

    always_comb begin
        neg  = result_i[DATA_W-1];
        zero = (result_i == '0);
        cc_o = {neg, !neg && !zero, zero, so_i};
    end
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
    import vseq_pkg::*;
#(
    parameter int VLW = VL_W,
    parameter int RW  = REG_W,
    parameter int DW  = DATA_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [VLW-1:0] vlen_i,
    input  logic [RW-1:0]  dst_base_i,
    input  logic [RW-1:0]  srca_base_i,
    input  logic [RW-1:0]  srcb_base_i,
    input  logic           dst_vec_i,
    input  logic           srca_vec_i,
    input  logic           srcb_vec_i,
    input  logic           rec_en_i,
    input  logic           issue_ready_i,
    input  logic [DW-1:0]  result_i,
    input  logic           so_i,
    output logic           issue_valid_o,
    output logic [RW-1:0]  issue_dst_o,
    output logic [RW-1:0]  issue_srca_o,
    output logic [RW-1:0]  issue_srcb_o,
    output logic [VLW-1:0] issue_crf_o,
    output logic           issue_rec_o,
    output logic           cc_valid_o,
    output logic [3:0]     cc_o,
    output logic           busy_o,
    output logic           done_o,
    output logic           err_o
);
    seq_state_t q, d;

    logic [N_OPS-1:0][REG_W-1:0] reg_num;
    logic [N_OPS-1:0]            reg_ovf;
    logic                        any_ovf;
    logic                        last_elem;
    logic                        fire;
    logic                        zero_start;

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        vseq_regcalc #(.REG_W(REG_W), .VL_W(VL_W)) u_calc (
            .base_i (q.base[g]),
            .vec_i  (q.vec[g]),
            .elem_i (q.elem),
            .reg_o  (reg_num[g]),
            .ovf_o  (reg_ovf[g])
        );
    end

    vseq_ccgen #(.DATA_W(DATA_W)) u_cc (
        .result_i (result_i),
        .so_i     (so_i),
        .cc_o     (cc_o)
    );

    always_comb begin
        any_ovf    = |reg_ovf;
        last_elem  = (q.elem == q.vl - 1'b1) || !q.vec[0];
        fire       = (q.st == ST_RUN) && !any_ovf && issue_ready_i;
        zero_start = start_i && (q.st == ST_IDLE) && (vlen_i == '0);

        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i && vlen_i != '0) begin
                    d.st   = ST_RUN;
                    d.elem = '0;
                    d.vl   = vlen_i;
                    d.base = {srcb_base_i, srca_base_i, dst_base_i};
                    d.vec  = {srcb_vec_i, srca_vec_i, dst_vec_i};
                    d.rec  = rec_en_i;
                end
            end
            ST_RUN: begin
                if (any_ovf) begin
                    d.st  = ST_IDLE;
                    d.err = 1'b1;
                end else if (issue_ready_i) begin
                    if (last_elem) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.elem = q.elem + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        busy_o        = (q.st == ST_RUN);
        issue_valid_o = busy_o && !any_ovf;
        issue_dst_o   = reg_num[0];
        issue_srca_o  = reg_num[1];
        issue_srcb_o  = reg_num[2];
        issue_crf_o   = q.elem;
        issue_rec_o   = q.rec;
        cc_valid_o    = fire;
        done_o        = q.done || zero_start;
        err_o         = q.err;
    end
endmodule

// File: rtl/vec_elem_seq_chk.sv
module vec_elem_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [6:0] vlen_i,
    input logic       busy_o,
    input logic       issue_valid_o,
    input logic       issue_ready_i,
    input logic [4:0] issue_dst_o,
    input logic [4:0] issue_srca_o,
    input logic [4:0] issue_srcb_o,
    input logic [6:0] issue_crf_o,
    input logic       cc_valid_o,
    input logic [3:0] cc_o,
    input logic       done_o,
    input logic       err_o
);
    assert_valid_only_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |-> busy_o);

    assert_index_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o && issue_ready_i) |=>
            (!issue_valid_o || issue_crf_o == $past(issue_crf_o) + 7'd1));

    assert_zero_len_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && vlen_i == 7'd0) |-> (done_o && !issue_valid_o));

    assert_cc_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cc_valid_o |-> $countones(cc_o[3:1]) == 1);

    assert_cc_only_on_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cc_valid_o |-> (issue_valid_o && issue_ready_i));

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o && !issue_ready_i) |=>
            (issue_valid_o && $stable(issue_crf_o) && $stable(issue_dst_o)
             && $stable(issue_srca_o) && $stable(issue_srcb_o)));

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !issue_valid_o);

    assert_err_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o);
endmodule

bind vec_elem_seq vec_elem_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .vlen_i        (vlen_i),
    .busy_o        (busy_o),
    .issue_valid_o (issue_valid_o),
    .issue_ready_i (issue_ready_i),
    .issue_dst_o   (issue_dst_o),
    .issue_srca_o  (issue_srca_o),
    .issue_srcb_o  (issue_srcb_o),
    .issue_crf_o   (issue_crf_o),
    .cc_valid_o    (cc_valid_o),
    .cc_o          (cc_o),
    .done_o        (done_o),
    .err_o         (err_o)
);

// File: tb/vec_elem_seq_test.sv
module vec_elem_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [6:0]  vlen_i = '0;
    logic [4:0]  dst_base_i = '0, srca_base_i = '0, srcb_base_i = '0;
    logic        dst_vec_i = 1'b0, srca_vec_i = 1'b0, srcb_vec_i = 1'b0;
    logic        rec_en_i = 1'b0;
    logic        issue_ready_i = 1'b0;
    logic [63:0] result_i = '0;
    logic        so_i = 1'b0;
    logic        issue_valid_o;
    logic [4:0]  issue_dst_o, issue_srca_o, issue_srcb_o;
    logic [6:0]  issue_crf_o;
    logic        issue_rec_o, cc_valid_o, busy_o, done_o, err_o;
    logic [3:0]  cc_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_elem_seq uut (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_cc(input logic [63:0] r, input logic so);
        if (r[63])        return {3'b100, so};
        else if (r == 0)  return {3'b001, so};
        else              return {3'b010, so};
    endfunction

    // one full loop, checked element by element
    task automatic run_loop(input int vl, input int db, input int ab, input int bb,
                            input bit dv, input bit av, input bit bv,
                            input bit rec, input bit stall);
        int n_elem, abort_at, k, cyc;
        bit ended;
        n_elem = (vl == 0) ? 0 : (dv ? vl : 1);
        abort_at = -1;
        for (int i = 0; i < n_elem; i++) begin
            if (abort_at < 0 && ((dv && db + i > 31) || (av && ab + i > 31) || (bv && bb + i > 31)))
                abort_at = i;
        end
        @(negedge clk);
        vlen_i = 7'(vl); dst_base_i = 5'(db); srca_base_i = 5'(ab); srcb_base_i = 5'(bb);
        dst_vec_i = dv; srca_vec_i = av; srcb_vec_i = bv; rec_en_i = rec;
        issue_ready_i = 1'b0; start_i = 1'b1;
        #1;
        if (vl == 0) begin
            chk(done_o == 1'b1, "R3 done with start", done_o, 1);
            chk(issue_valid_o == 1'b0, "R3 no issue", issue_valid_o, 0);
        end
        @(negedge clk);
        start_i = 1'b0;
        if (vl == 0) begin
            #1;
            chk(busy_o == 1'b0 && issue_valid_o == 1'b0, "R3 stays idle", busy_o, 0);
            return;
        end
        k = 0; ended = 1'b0;
        for (cyc = 0; cyc < 400 && !ended; cyc++) begin
            if (cyc != 0) @(negedge clk);
            issue_ready_i = stall ? cyc[0] : 1'b1;
            case (k % 3)
                0: result_i = 64'd0;
                1: result_i = 64'h1234 + 64'(k);
                default: result_i = -64'(k + 1);
            endcase
            so_i = k[1];
            #1;
            if (issue_valid_o) begin
                chk(issue_dst_o  == 5'(db + (dv ? k : 0)), "R4/R5/R6 dst", issue_dst_o, db + (dv ? k : 0));
                chk(issue_srca_o == 5'(ab + (av ? k : 0)), "R4/R5 srca", issue_srca_o, ab + (av ? k : 0));
                chk(issue_srcb_o == 5'(bb + (bv ? k : 0)), "R4/R5 srcb", issue_srcb_o, bb + (bv ? k : 0));
                chk(issue_crf_o == 7'(k), "R2/R7 crf index", issue_crf_o, k);
                chk(issue_rec_o == rec, "R7 rec flag", issue_rec_o, rec);
                chk(cc_valid_o == issue_ready_i, "R8/R9 cc valid", cc_valid_o, issue_ready_i);
                if (issue_ready_i) begin
                    chk(cc_o == exp_cc(result_i, so_i), "R8 cc", cc_o, exp_cc(result_i, so_i));
                    k++;
                end
            end else if (!busy_o) begin
                ended = 1'b1;
                chk(done_o == (abort_at < 0), "R10 done pulse", done_o, abort_at < 0);
                chk(err_o == (abort_at >= 0), "R11 err pulse", err_o, abort_at >= 0);
            end
        end
        chk(k == ((abort_at < 0) ? n_elem : abort_at), "R2/R6/R11 element count",
            k, (abort_at < 0) ? n_elem : abort_at);
        @(negedge clk);
        chk(done_o == 1'b0 && err_o == 1'b0, "R10/R11 single-cycle pulse", {done_o, err_o}, 0);
    endtask

    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(busy_o == 0 && issue_valid_o == 0 && done_o == 0 && err_o == 0,
            "R1 reset idle", {busy_o, issue_valid_o, done_o, err_o}, 0);
        rst_n = 1'b1;

        // sweep length, operand markers and ready pattern
        for (int vl = 0; vl <= 5; vl++)
            for (int f = 0; f < 8; f++)
                for (int s = 0; s < 2; s++)
                    run_loop(vl, 3, 5, 9, f[0], f[1], f[2], f[0] ^ s[0], s[0]);

        // register range abort
        run_loop(10, 1, 28, 2, 1, 1, 0, 1, 0);
        run_loop(10, 30, 4, 2, 1, 0, 1, 0, 1);
        run_loop(40, 0, 0, 0, 1, 1, 1, 1, 0);
        // scalar destination hides a would-be overflow
        run_loop(10, 1, 31, 2, 0, 1, 1, 1, 0);
        // edge base exactly reaching 31
        run_loop(4, 28, 0, 0, 1, 0, 0, 0, 1);

        // R1: start while busy is ignored
        @(negedge clk);
        vlen_i = 7'd3; dst_base_i = 5'd4; srca_base_i = 5'd6; srcb_base_i = 5'd8;
        dst_vec_i = 1; srca_vec_i = 1; srcb_vec_i = 0; rec_en_i = 1;
        issue_ready_i = 0; start_i = 1;
        @(negedge clk);
        vlen_i = 7'd1; dst_base_i = 5'd20; srca_base_i = 5'd21; srcb_base_i = 5'd22;
        dst_vec_i = 0; start_i = 1;
        @(negedge clk);
        start_i = 0;
        for (int k = 0; k < 3; k++) begin
            issue_ready_i = 1; result_i = 64'd5; so_i = 0;
            #1;
            chk(issue_valid_o && issue_dst_o == 5'(4 + k) && issue_srca_o == 5'(6 + k)
                && issue_srcb_o == 5'd8, "R1 busy start ignored", issue_dst_o, 4 + k);
            @(negedge clk);
        end
        #1;
        chk(done_o == 1'b1 && busy_o == 1'b0, "R1/R10 original loop completes", done_o, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule